// File: doc/BRIEF.md
# GNSS Tracking Correlator Channel

This block is one tracking channel of a satellite navigation baseband. Each clock cycle it takes one 2-bit intermediate-frequency sample and multiplies it by the cosine and the sine of a local carrier. A programmable carrier NCO and one shared pair of coarse lookup tables supply those values, and the result is an in-phase (I) and a quadrature (Q) product. A second NCO sets the spreading-code rate and clocks a configurable LFSR code generator. The code bits pass through a three-stage shift register that supplies early, prompt and late replicas a third of a chip apart. Each replica despreads the I and Q products, and six integrate-and-dump accumulators sum the results over a programmable number of samples.

Software steers the channel through a write-only register port. It can set the carrier and code frequency words, the LFSR seed and feedback mask, the integration length and the sample format, and it can trigger a soft restart that re-aligns all phases. When an integration period ends, the six sums appear together on the outputs with a one-cycle valid strobe. The next period starts in the same cycle, so no sample is dropped. The accumulators are sized from the worst-case product magnitude and the largest supported period, so they cannot wrap.

Top module: `gnss_trk_chan`

## Requirements
- R1: The control register (address 5) bit 0 selects the sample format. When it is 1, the raw pair is two's complement (01=+3, 00=+1, 11=-1, 10=-3). When it is 0, the raw pair is offset binary (11=+3, 10=+1, 01=-1, 00=-3).
- R2: The carrier phase (32 bits) advances by the carrier word (address 0) each sample and restarts at 0 on a soft restart. Its top 3 bits index the tables: cos = 2,1,-1,-2,-2,-1,1,2 and sin = 1,2,2,1,-1,-2,-2,-1 for indices 0 to 7. I = sample*cos and Q = sample*sin.
- R3: The code phase (32 bits) adds the code word (address 1) each sample. Each carry out is a third-chip tick, and the LFSR steps on every third tick.
- R4: The LFSR is seeded from address 2. Its feedback mask comes from address 3. On a step it shifts left and takes the parity of (state AND mask) into bit 0. Its code bit is the state MSB, where bit 0 gives replica +1 and bit 1 gives replica -1.
- R5: On every tick, the code bit enters a 3-stage shift register that is cleared on a soft restart. The early replica is stage 0, prompt is stage 1 and late is stage 2, so adjacent arms are one tick apart. Each replica in use is the value held at the start of the sample's cycle.
- R6: Each arm has its own I and Q sum. After L samples, the six sums move to the outputs and the valid output is high for exactly one cycle, L+1 clock edges after the restart edge. The sums restart from the current products, so no sample is lost.
- R7: An integration length (address 4) of 0 acts as 1, which dumps every sample. A length above MAX_INT acts as MAX_INT.
- R8: The accumulators are 4 + ceil(log2(MAX_INT)) bits wide. A full MAX_INT period at the largest product magnitude (6) gives the exact value, with no wrap.
- R9: Writing 1 to control bit 1 is a soft restart. It clears both NCO phases, the tick divider, the shift register, the sums and the sample count, and it reloads the LFSR from the seed.
- R10: After hardware reset, all six outputs are 0 and the valid output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_sample | input | 2 | Digitized IF sample, one per cycle |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address (0..5) |
| cfg_wdata | input | 32 | Register write data |
| e_i | output | ACC_W | Early arm in-phase sum |
| e_q | output | ACC_W | Early arm quadrature sum |
| p_i | output | ACC_W | Prompt arm in-phase sum |
| p_q | output | ACC_W | Prompt arm quadrature sum |
| l_i | output | ACC_W | Late arm in-phase sum |
| l_q | output | ACC_W | Late arm quadrature sum |
| dump_valid | output | 1 | One-cycle strobe when new sums are presented |

## Verification
With the carrier stopped and a constant sample, every raw code in both formats is fed in. Each one gives a distinct sum, which separates the two decodes and the level mapping. A carrier word of one table step per sample, with a two-sample period, shows whether the table index, its order and the sign of each table are right. Several code words, seeds and masks are compared against an independent model of the code path. The code word sets the tick density and a mismatch shows up differently on the early, prompt and late arms, so arm order, tap spacing and the divide-by-three are each exposed. A length of 0, a full-length period with both signs, and a restart that follows activity cover the edge behaviour.

// File: rtl/gnss_trk_chan.sv
module gnss_trk_chan #(
  parameter int NCO_W = 32,
  parameter int LFSR_W = 10,
  parameter int MAX_INT = 225000,
  parameter logic [LFSR_W-1:0] SEED_INIT = '1,
  parameter logic [LFSR_W-1:0] TAPS_INIT = LFSR_W'(10'h204),
  localparam int MIX_W = 4,
  localparam int CNT_W = $clog2(MAX_INT + 1),
  localparam int ACC_W = MIX_W + $clog2(MAX_INT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              if_sample,
  input  logic                    cfg_we,
  input  logic [2:0]              cfg_addr,
  input  logic [31:0]             cfg_wdata,
  output logic signed [ACC_W-1:0] e_i,
  output logic signed [ACC_W-1:0] e_q,
  output logic signed [ACC_W-1:0] p_i,
  output logic signed [ACC_W-1:0] p_q,
  output logic signed [ACC_W-1:0] l_i,
  output logic signed [ACC_W-1:0] l_q,
  output logic                    dump_valid
);

  logic [NCO_W-1:0] carr_fcw, code_fcw, car_ph, code_ph;
  logic [LFSR_W-1:0] seed, taps, lf;
  logic [31:0] int_len;
  logic fmt_twos;
  logic [1:0] div;
  logic [2:0] sr;
  logic [CNT_W-1:0] cnt, eff_len;
  logic signed [ACC_W-1:0] acc [0:5];
  logic signed [ACC_W-1:0] outr [0:5];
  logic signed [MIX_W-1:0] prod [0:5];
  logic signed [MIX_W-1:0] mi, mq;
  logic signed [2:0] smp, cosv, sinv;
  logic [NCO_W:0] csum;
  logic tick, srst;

  assign srst = cfg_we && (cfg_addr == 3'd5) && cfg_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carr_fcw <= '0;
      code_fcw <= '0;
      seed     <= SEED_INIT;
      taps     <= TAPS_INIT;
      int_len  <= 32'd1;
      fmt_twos <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: carr_fcw <= cfg_wdata[NCO_W-1:0];
        3'd1: code_fcw <= cfg_wdata[NCO_W-1:0];
        3'd2: seed     <= cfg_wdata[LFSR_W-1:0];
        3'd3: taps     <= cfg_wdata[LFSR_W-1:0];
        3'd4: int_len  <= cfg_wdata;
        3'd5: fmt_twos <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    if (int_len == '0)                eff_len = CNT_W'(1);
    else if (int_len > 32'(MAX_INT))  eff_len = CNT_W'(MAX_INT);
    else                              eff_len = int_len[CNT_W-1:0];
  end

  assign smp = fmt_twos ? {if_sample, 1'b1} : {~if_sample[1], if_sample[0], 1'b1};

  always_comb begin
    case (car_ph[NCO_W-1 -: 3])
      3'd0: begin cosv = 3'sd2;  sinv = 3'sd1;  end
      3'd1: begin cosv = 3'sd1;  sinv = 3'sd2;  end
      3'd2: begin cosv = -3'sd1; sinv = 3'sd2;  end
      3'd3: begin cosv = -3'sd2; sinv = 3'sd1;  end
      3'd4: begin cosv = -3'sd2; sinv = -3'sd1; end
      3'd5: begin cosv = -3'sd1; sinv = -3'sd2; end
      3'd6: begin cosv = 3'sd1;  sinv = -3'sd2; end
      default: begin cosv = 3'sd2; sinv = -3'sd1; end
    endcase
  end

  assign mi = MIX_W'(smp) * MIX_W'(cosv);
  assign mq = MIX_W'(smp) * MIX_W'(sinv);

  always_comb begin
    for (int k = 0; k < 3; k++) begin
      prod[2*k]   = sr[k] ? -mi : mi;
      prod[2*k+1] = sr[k] ? -mq : mq;
    end
  end

  assign csum = {1'b0, code_ph} + {1'b0, code_fcw};
  assign tick = csum[NCO_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_ph <= '0; code_ph <= '0; div <= '0; lf <= SEED_INIT; sr <= '0;
      cnt <= '0; dump_valid <= 1'b0;
      for (int k = 0; k < 6; k++) begin acc[k] <= '0; outr[k] <= '0; end
    end else if (srst) begin
      car_ph <= '0; code_ph <= '0; div <= '0; lf <= seed; sr <= '0;
      cnt <= '0; dump_valid <= 1'b0;
      for (int k = 0; k < 6; k++) acc[k] <= '0;
    end else begin
      car_ph  <= car_ph + carr_fcw;
      code_ph <= csum[NCO_W-1:0];
      if (tick) begin
        sr <= {sr[1:0], lf[LFSR_W-1]};
        if (div == 2'd2) begin
          div <= '0;
          lf  <= {lf[LFSR_W-2:0], ^(lf & taps)};
        end else begin
          div <= div + 2'd1;
        end
      end
      if (cnt >= eff_len) begin
        dump_valid <= 1'b1;
        cnt <= CNT_W'(1);
        for (int k = 0; k < 6; k++) begin
          outr[k] <= acc[k];
          acc[k]  <= ACC_W'(prod[k]);
        end
      end else begin
        dump_valid <= 1'b0;
        cnt <= cnt + CNT_W'(1);
        for (int k = 0; k < 6; k++) acc[k] <= acc[k] + ACC_W'(prod[k]);
      end
    end
  end

  assign e_i = outr[0];
  assign e_q = outr[1];
  assign p_i = outr[2];
  assign p_q = outr[3];
  assign l_i = outr[4];
  assign l_q = outr[5];

  assert_sr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !srst) |=> $stable(sr));
  assert_sr_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !srst) |=> (sr[2:1] == $past(sr[1:0])));
  assert_lfsr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && div == 2'd2) && !srst) |=> $stable(lf));
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (car_ph == '0 && code_ph == '0 && lf == $past(seed) && cnt == '0 && !dump_valid));
  assert_one_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_valid && eff_len > CNT_W'(1)) |=> !dump_valid);
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_INT));

endmodule

// File: tb/sim_gnss_trk_chan.sv
module sim_gnss_trk_chan;
  localparam int MAXI = 1000;
  localparam int AW = 4 + $clog2(MAXI);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] if_sample = 2'b01;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic signed [AW-1:0] e_i, e_q, p_i, p_q, l_i, l_q;
  logic dump_valid;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  gnss_trk_chan #(.MAX_INT(MAXI)) u0 (
    .clk(clk), .rst_n(rst_n), .if_sample(if_sample), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .e_i(e_i), .e_q(e_q),
    .p_i(p_i), .p_q(p_q), .l_i(l_i), .l_q(l_q), .dump_valid(dump_valid));

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic arms(input string req, input int ei, input int eq);
    chk({req, " early I"}, int'(e_i), ei);
    chk({req, " early Q"}, int'(e_q), eq);
    chk({req, " prompt I"}, int'(p_i), ei);
    chk({req, " prompt Q"}, int'(p_q), eq);
    chk({req, " late I"}, int'(l_i), ei);
    chk({req, " late Q"}, int'(l_q), eq);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!dump_valid && n < 5000);
  endtask

  task automatic setup(input logic [31:0] cf, input logic [31:0] kf, input logic [31:0] len);
    wr(3'd0, cf); wr(3'd1, kf); wr(3'd4, len);
  endtask

  task automatic t_reset_R10;
    chk("R10 valid low", int'(dump_valid), 0);
    arms("R10 zero", 0, 0);
  endtask

  task automatic t_decode_R1(input bit twos, input logic [1:0] raw, input int s);
    int n;
    if_sample = raw;
    setup(32'd0, 32'd0, 32'd4);
    wr(3'd5, {30'd0, 1'b1, twos});
    wait_valid(n);
    arms($sformatf("R1 fmt=%0d raw=%0d", twos, raw), 8 * s, 4 * s);
  endtask

  task automatic t_carrier_R2;
    int n;
    if_sample = 2'b01;
    setup(32'h2000_0000, 32'd0, 32'd2);
    wr(3'd5, 32'd3);
    wait_valid(n);
    chk("R6 first dump at edge L+1", n, 3);
    arms("R2 phases 0,1", 9, 9);
    @(negedge clk);
    chk("R6 single-cycle valid", int'(dump_valid), 0);
    @(negedge clk);
    chk("R6 next dump without gap", int'(dump_valid), 1);
    arms("R2 phases 2,3", -9, 9);
    @(negedge clk); @(negedge clk);
    arms("R2 phases 4,5", -9, -9);
  endtask

  task automatic t_len0_R7;
    int n;
    if_sample = 2'b01;
    setup(32'd0, 32'd0, 32'd0);
    wr(3'd5, 32'd3);
    wait_valid(n);
    for (int k = 0; k < 3; k++) begin
      chk("R7 len 0 dumps every cycle", int'(dump_valid), 1);
      chk("R7 single-sample I", int'(p_i), 6);
      @(negedge clk);
    end
    setup(32'd0, 32'd0, 32'd5000);
    wr(3'd5, 32'd3);
    wait_valid(n);
    chk("R7 oversize length clamps", n, MAXI + 1);
  endtask

  task automatic t_full_R8(input bit twos, input logic [1:0] raw, input int s);
    int n;
    if_sample = raw;
    setup(32'd0, 32'd0, MAXI);
    wr(3'd5, {30'd0, 1'b1, twos});
    wait_valid(n);
    chk("R8 full period timing", n, MAXI + 1);
    arms("R8 full period sum", 2 * s * MAXI, s * MAXI);
  endtask

  task automatic t_code(input logic [31:0] fcw, input logic [9:0] sd,
                        input logic [9:0] tp, input int len, input int nd);
    logic [32:0] sum;
    logic [31:0] ph;
    logic [9:0] lf;
    logic [2:0] sr;
    int dv, cnt, got, vbad;
    int acc [3];
    int mo [3];
    bit mv;
    if_sample = 2'b01;
    setup(32'd0, fcw, len);
    wr(3'd2, {22'd0, sd});
    wr(3'd3, {22'd0, tp});
    wr(3'd5, 32'd3);
    ph = '0; lf = sd; sr = '0; dv = 0; cnt = 0; got = 0; vbad = 0; mv = 1'b0;
    for (int k = 0; k < 3; k++) begin acc[k] = 0; mo[k] = 0; end
    for (int c = 0; c < nd * (len + 1) + 4 && got < nd; c++) begin
      if (int'(dump_valid) != int'(mv)) vbad++;
      if (mv) begin
        got++;
        chk("R5 early I", int'(e_i), 6 * mo[0]);
        chk("R5 early Q", int'(e_q), 3 * mo[0]);
        chk("R4 prompt I", int'(p_i), 6 * mo[1]);
        chk("R4 prompt Q", int'(p_q), 3 * mo[1]);
        chk("R3 late I", int'(l_i), 6 * mo[2]);
        chk("R3 late Q", int'(l_q), 3 * mo[2]);
      end
      if (cnt >= len) begin
        mv = 1'b1; cnt = 1;
        for (int k = 0; k < 3; k++) begin
          mo[k] = acc[k];
          acc[k] = sr[k] ? -1 : 1;
        end
      end else begin
        mv = 1'b0; cnt++;
        for (int k = 0; k < 3; k++) acc[k] += sr[k] ? -1 : 1;
      end
      sum = {1'b0, ph} + {1'b0, fcw};
      ph = sum[31:0];
      if (sum[32]) begin
        sr = {sr[1:0], lf[9]};
        if (dv == 2) begin
          dv = 0;
          lf = {lf[8:0], ^(lf & tp)};
        end else dv++;
      end
      @(negedge clk);
    end
    chk("R6 dump strobe pattern", vbad, 0);
    chk("R6 dump count", got, nd);
  endtask

  task automatic t_restart_R9;
    int n;
    if_sample = 2'b01;
    setup(32'h2000_0000, 32'h4321_0000, 32'd2);
    repeat (13) @(negedge clk);
    wr(3'd5, 32'd3);
    wait_valid(n);
    chk("R9 restart realigns dump", n, 3);
    arms("R9 carrier phase cleared", 9, 9);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(10 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_R10();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_R10();
    t_decode_R1(1'b1, 2'b01, 3);
    t_decode_R1(1'b1, 2'b00, 1);
    t_decode_R1(1'b1, 2'b11, -1);
    t_decode_R1(1'b1, 2'b10, -3);
    t_decode_R1(1'b0, 2'b11, 3);
    t_decode_R1(1'b0, 2'b10, 1);
    t_decode_R1(1'b0, 2'b01, -1);
    t_decode_R1(1'b0, 2'b00, -3);
    t_carrier_R2();
    t_len0_R7();
    t_full_R8(1'b1, 2'b10, -3);
    t_full_R8(1'b0, 2'b11, 3);
    t_code(32'h8000_0000, 10'h3FF, 10'h204, 7, 8);
    t_code(32'h5555_5555, 10'h155, 10'h3A6, 10, 8);
    t_code(32'hF000_0000, 10'h0B3, 10'h204, 5, 10);
    t_code(32'hF000_0000, 10'h0B3, 10'h204, 5, 10);
    t_restart_R9();
    finish_up();
  end
endmodule